// File: doc/BRIEF.md
# Length-Framed Nibble Link Transmitter

This block sends one packet at a time over a five-wire point-to-point link: four data lines and one handshake line in each direction. A packet is opened by a start exchange carried on the data lines. The sender raises a fixed request pattern and waits until the peer answers with its own fixed pattern. After that, every byte crosses in two nibbles under a four-phase handshake.

Each frame carries fields in a fixed order. First comes a 16-bit frame length, low byte first. Then come the address bytes from a configuration bank, two fixed type bytes and the payload. The frame closes with an 8-bit additive checksum. The payload arrives on a valid/ready byte stream, and its byte count is given when the packet is started. The frame needs no end marker: the receiver works out the end from the length field. After the last byte, the lines return to all zeros.

If the peer stays silent during the start exchange, or misses any handshake edge, for longer than a programmable number of cycles, the packet is abandoned. The block then raises an error pulse and clears the lines.

Top module: `nlt_tx`

## Requirements
- R1: After reset, and whenever no packet is in progress, `link_o` is all zeros, `busy_o` is low and `pay_ready_o` is low.
- R2: A high `start_i` while idle starts a packet. The block drives `link_o` = 5'b01000 (data value 8, handshake low) and sends no byte until `link_i` equals 5'b00001 (data value 1, handshake low).
- R3: Bits 3:0 of `link_o`/`link_i` are data and bit 4 is the handshake. For each byte, `link_o` shows {1, low nibble} until `link_i[4]` is high. It then shows {0, high nibble} until `link_i[4]` is low.
- R4: The first two bytes are the frame length, low byte first. Its value is the payload count plus 14.
- R5: Then come 12 address bytes, where byte k is `addr_cfg_i[8k+7:8k]`. These are followed by 8'h08, then 8'h00, then the payload bytes in the order they were accepted on the stream.
- R6: The final byte is the modulo-256 sum of the address bytes, the two type bytes and the payload. The sum starts from zero for every packet, including a packet that follows an aborted one.
- R7: After the peer lowers its handshake for the checksum byte, `link_o` returns to zero, `busy_o` falls and `done_o` pulses for one cycle. `done_o` and `err_o` are never high together.
- R8: If a wait phase (the start answer or a handshake edge) lasts `timeout_cfg_i`+1 cycles without being met, the block aborts. It pulses `err_o` for one cycle, clears `link_o` and becomes idle without sending the remaining bytes.
- R9: While a payload byte is due and `pay_valid_i` is low, `link_o` holds steady. Such a stall never triggers the timeout.
- R10: `start_i` is ignored while a packet is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a packet (sampled while idle) |
| pay_len_i | input | PAY_W | Payload byte count for the packet being started |
| pay_data_i | input | 8 | Payload stream byte |
| pay_valid_i | input | 1 | Payload byte present |
| pay_ready_o | output | 1 | Payload byte taken this cycle when valid |
| addr_cfg_i | input | 8*ADDR_BYTES | Address field bank, byte k in bits 8k+7:8k |
| timeout_cfg_i | input | TMO_W | Allowed extra wait cycles per link phase |
| link_i | input | 5 | Peer lines: data 3:0, handshake 4 |
| link_o | output | 5 | Own lines: data 3:0, handshake 4 |
| busy_o | output | 1 | Packet in progress |
| done_o | output | 1 | One-cycle pulse when a packet completes |
| err_o | output | 1 | One-cycle pulse when a packet is aborted |

## Verification
The assertions assume that the peer changes `link_i` only between clock edges. They also assume that the peer lowers its handshake only after the block has lowered its own. The bench's peer model follows both rules: it acts only on falling clock edges and answers each phase of the block in turn. The stream is assumed to hold a byte steady until it is taken. The bench advances its payload pointer only after a cycle in which valid and ready were both high. Pattern 5'b01000 can also occur in the middle of a packet. For that reason, no property treats it as a start request except on the cycle in which `busy_o` rises.

// File: rtl/nlt_pkg.sv
package nlt_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_REQ,
      ST_LOAD,
      ST_LO,
      ST_HI
   } tx_state_e;

   localparam int          LINK_W     = 5;
   localparam int          HS_BIT     = 4;
   localparam logic [4:0]  LINK_REQ   = 5'b01000;
   localparam logic [4:0]  LINK_GRANT = 5'b00001;
   localparam logic [7:0]  TYPE_B0    = 8'h08;
   localparam logic [7:0]  TYPE_B1    = 8'h00;
endpackage

// File: rtl/nlt_wait_timer.sv
module nlt_wait_timer #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   input  logic [CNT_W-1:0] limit,
   output logic             hit
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (clr)    cnt_q <= '0;
      else if (inc)    cnt_q <= cnt_q + 1'b1;
   end

   assign hit = (cnt_q == limit);
endmodule

// File: rtl/nlt_csum_acc.sv
module nlt_csum_acc #(
   parameter int SUM_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             add,
   input  logic [SUM_W-1:0] din,
   output logic [SUM_W-1:0] sum
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    sum <= '0;
      else if (clr)  sum <= '0;
      else if (add)  sum <= sum + din;
   end
endmodule

// File: rtl/nlt_byte_mux.sv
module nlt_byte_mux
   import nlt_pkg::*;
#(
   parameter int ADDR_BYTES = 12,
   parameter int PAY_W      = 11,
   parameter int IDX_W      = 12
) (
   input  logic [IDX_W-1:0]        idx,
   input  logic [PAY_W-1:0]        pay_len,
   input  logic [15:0]             frame_len,
   input  logic [8*ADDR_BYTES-1:0] addr_bank,
   input  logic [7:0]              pay_byte,
   input  logic [7:0]              sum,
   output logic [7:0]              cur_byte,
   output logic                    in_pay,
   output logic                    in_span,
   output logic                    is_last
);
   localparam int AB_LO  = 2;
   localparam int AB_END = AB_LO + ADDR_BYTES;
   localparam int HDR    = AB_END + 2;

   localparam logic [IDX_W-1:0] I_ABLO = IDX_W'(AB_LO);
   localparam logic [IDX_W-1:0] I_T0   = IDX_W'(AB_END);
   localparam logic [IDX_W-1:0] I_T1   = IDX_W'(AB_END + 1);
   localparam logic [IDX_W-1:0] I_HDR  = IDX_W'(HDR);

   logic [7:0]       addr_arr [ADDR_BYTES];
   logic [IDX_W-1:0] pay_end;

   for (genvar k = 0; k < ADDR_BYTES; k++) begin : g_addr
      assign addr_arr[k] = addr_bank[8*k +: 8];
   end

   assign pay_end = I_HDR + IDX_W'(pay_len);

   always_comb begin
      in_pay  = (idx >= I_HDR) && (idx < pay_end);
      in_span = (idx >= I_ABLO) && (idx < pay_end);
      is_last = (idx == pay_end);
      cur_byte = sum;
      if (idx == '0)              cur_byte = frame_len[7:0];
      else if (idx == IDX_W'(1))  cur_byte = frame_len[15:8];
      else if (idx == I_T0)       cur_byte = TYPE_B0;
      else if (idx == I_T1)       cur_byte = TYPE_B1;
      else if (in_pay)            cur_byte = pay_byte;
      else begin
         for (int k = 0; k < ADDR_BYTES; k++) begin
            if (idx == IDX_W'(AB_LO + k)) cur_byte = addr_arr[k];
         end
      end
   end
endmodule

// File: rtl/nlt_tx.sv
module nlt_tx
   import nlt_pkg::*;
#(
   parameter int ADDR_BYTES = 12,
   parameter int PAY_W      = 11,
   parameter int TMO_W      = 16,
   parameter bit TIMEOUT_EN = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start_i,
   input  logic [PAY_W-1:0]        pay_len_i,
   input  logic [7:0]              pay_data_i,
   input  logic                    pay_valid_i,
   output logic                    pay_ready_o,
   input  logic [8*ADDR_BYTES-1:0] addr_cfg_i,
   input  logic [TMO_W-1:0]        timeout_cfg_i,
   input  logic [4:0]              link_i,
   output logic [4:0]              link_o,
   output logic                    busy_o,
   output logic                    done_o,
   output logic                    err_o
);
   localparam int HDR_BYTES = ADDR_BYTES + 4;
   localparam int LEN_OFS   = ADDR_BYTES + 2;
   localparam int IDX_W     = $clog2((1 << PAY_W) + HDR_BYTES + 1);

   if (ADDR_BYTES < 1) begin : g_bad_addr
      $error("nlt_tx: ADDR_BYTES must be at least 1");
   end
   if (PAY_W < 1 || ((1 << PAY_W) - 1 + LEN_OFS) > 65535) begin : g_bad_pay
      $error("nlt_tx: PAY_W must let the frame length fit 16 bits");
   end
   if (TMO_W < 1) begin : g_bad_tmo
      $error("nlt_tx: TMO_W must be at least 1");
   end

   tx_state_e        st_q, st_d;
   logic [4:0]       lo_q, lo_d;
   logic [IDX_W-1:0] idx_q, idx_d;
   logic [PAY_W-1:0] plen_q;
   logic [15:0]      flen_q;
   logic [7:0]       byte_q;
   logic             last_q;
   logic             done_q, err_q;

   logic [7:0]       cur_byte, sum;
   logic             in_pay, in_span, is_last;
   logic             waiting, cond, abort, take, accept, finish, hit;
   logic             peer_hs;

   assign peer_hs = link_i[HS_BIT];
   assign accept  = (st_q == ST_IDLE) && start_i;

   nlt_byte_mux #(
      .ADDR_BYTES (ADDR_BYTES),
      .PAY_W      (PAY_W),
      .IDX_W      (IDX_W)
   ) u_mux (
      .idx       (idx_q),
      .pay_len   (plen_q),
      .frame_len (flen_q),
      .addr_bank (addr_cfg_i),
      .pay_byte  (pay_data_i),
      .sum       (sum),
      .cur_byte  (cur_byte),
      .in_pay    (in_pay),
      .in_span   (in_span),
      .is_last   (is_last)
   );

   nlt_csum_acc #(.SUM_W(8)) u_sum (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (accept),
      .add   (take && in_span),
      .din   (cur_byte),
      .sum   (sum)
   );

   if (TIMEOUT_EN) begin : g_tmo
      nlt_wait_timer #(.CNT_W(TMO_W)) u_tmr (
         .clk   (clk),
         .rst_n (rst_n),
         .clr   (st_d != st_q),
         .inc   (waiting && !cond && !hit),
         .limit (timeout_cfg_i),
         .hit   (hit)
      );
   end else begin : g_no_tmo
      assign hit = 1'b0;
   end

   always_comb begin
      st_d    = st_q;
      lo_d    = lo_q;
      idx_d   = idx_q;
      waiting = 1'b0;
      cond    = 1'b0;
      take    = 1'b0;
      finish  = 1'b0;
      case (st_q)
         ST_IDLE: begin
            lo_d  = '0;
            idx_d = '0;
            if (start_i) begin
               st_d = ST_REQ;
               lo_d = LINK_REQ;
            end
         end
         ST_REQ: begin
            waiting = 1'b1;
            cond    = (link_i == LINK_GRANT);
            if (cond) st_d = ST_LOAD;
         end
         ST_LOAD: begin
            if (!in_pay || pay_valid_i) begin
               take = 1'b1;
               st_d = ST_LO;
               lo_d = {1'b1, cur_byte[3:0]};
            end
         end
         ST_LO: begin
            waiting = 1'b1;
            cond    = peer_hs;
            if (cond) begin
               st_d = ST_HI;
               lo_d = {1'b0, byte_q[7:4]};
            end
         end
         ST_HI: begin
            waiting = 1'b1;
            cond    = !peer_hs;
            if (cond) begin
               if (last_q) begin
                  st_d   = ST_IDLE;
                  lo_d   = '0;
                  finish = 1'b1;
               end else begin
                  st_d  = ST_LOAD;
                  idx_d = idx_q + 1'b1;
               end
            end
         end
         default: begin
            st_d = ST_IDLE;
            lo_d = '0;
         end
      endcase
      abort = waiting && !cond && hit;
      if (abort) begin
         st_d = ST_IDLE;
         lo_d = '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         lo_q   <= '0;
         idx_q  <= '0;
         plen_q <= '0;
         flen_q <= '0;
         byte_q <= '0;
         last_q <= 1'b0;
         done_q <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         st_q   <= st_d;
         lo_q   <= lo_d;
         idx_q  <= idx_d;
         done_q <= finish;
         err_q  <= abort;
         if (accept) begin
            plen_q <= pay_len_i;
            flen_q <= 16'(pay_len_i) + 16'(LEN_OFS);
         end
         if (take) begin
            byte_q <= cur_byte;
            last_q <= is_last;
         end
      end
   end

   assign link_o      = lo_q;
   assign busy_o      = (st_q != ST_IDLE);
   assign pay_ready_o = (st_q == ST_LOAD) && in_pay;
   assign done_o      = done_q;
   assign err_o       = err_q;
endmodule

// File: rtl/nlt_tx_chk.sv
module nlt_tx_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [4:0] link_i,
   input logic [4:0] link_o,
   input logic       busy_o,
   input logic       done_o,
   input logic       err_o,
   input logic       pay_ready_o,
   input logic       pay_valid_i
);
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (link_o == 5'b00000 && !pay_ready_o)); // R1

   AST_REQ_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> (link_o == 5'b01000)); // R2

   AST_HS_FALL_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(link_o[4]) && !err_o) |-> $past(link_i[4])); // R3

   AST_DONE_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> ($past(!link_i[4]) && link_o == 5'b00000 && !busy_o)); // R7

   AST_END_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_o && err_o)); // R7

   AST_ABORT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> (link_o == 5'b00000 && !busy_o && $past(busy_o))); // R8

   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (pay_ready_o && !pay_valid_i) |=> ($stable(link_o) && busy_o && !err_o)); // R9
endmodule

bind nlt_tx nlt_tx_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .link_i      (link_i),
   .link_o      (link_o),
   .busy_o      (busy_o),
   .done_o      (done_o),
   .err_o       (err_o),
   .pay_ready_o (pay_ready_o),
   .pay_valid_i (pay_valid_i)
);

// File: tb/tb_nlt_tx.sv
module tb_nlt_tx;
   localparam int CLK_PERIOD = 10;
   localparam int AB   = 12;
   localparam int PW   = 11;
   localparam int TW   = 16;

   typedef struct packed {
      logic [7:0]  plen;
      logic [7:0]  base;
      logic [7:0]  step;
      logic [3:0]  dly;
      logic [7:0]  salt;
      logic [15:0] exp_len;
   } vec_t;

   localparam vec_t VECS [0:4] = '{
      '{8'd0,  8'h00, 8'h00, 4'd0, 8'h00, 16'd14},
      '{8'd1,  8'hFF, 8'h00, 4'd1, 8'h11, 16'd15},
      '{8'd5,  8'h10, 8'h01, 4'd0, 8'h22, 16'd19},
      '{8'd20, 8'hF0, 8'h13, 4'd2, 8'h33, 16'd34},
      '{8'd40, 8'h80, 8'h80, 4'd3, 8'hEE, 16'd54}
   };

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            start_i = 1'b0;
   logic [PW-1:0]   pay_len_i = '0;
   logic [7:0]      pay_data_i = '0;
   logic            pay_valid_i = 1'b0;
   logic            pay_ready_o;
   logic [8*AB-1:0] addr_cfg_i = '0;
   logic [TW-1:0]   timeout_cfg_i = '0;
   logic [4:0]      link_i = '0;
   logic [4:0]      link_o;
   logic            busy_o, done_o, err_o;

   nlt_tx #(.ADDR_BYTES(AB), .PAY_W(PW), .TMO_W(TW)) dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .pay_len_i(pay_len_i),
      .pay_data_i(pay_data_i), .pay_valid_i(pay_valid_i), .pay_ready_o(pay_ready_o),
      .addr_cfg_i(addr_cfg_i), .timeout_cfg_i(timeout_cfg_i), .link_i(link_i),
      .link_o(link_o), .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int n_chk = 0, n_fail = 0;
   logic [7:0] pbuf [0:63];
   logic [7:0] rx   [0:127];
   int plen = 0, pidx = 0, nrx = 0;
   bit pend = 0;
   int stall_at = -1, stall_len = 0, stall_cnt = 0;
   int peer_dly = 0, pcnt = 0, pst = 0, mute_at = -1;
   bit mute_start = 0;
   logic [3:0] lo_nib;
   logic [4:0] first_lo, first_hi;
   bit got_done, got_err;
   int busy_cyc;

   // payload stream and peer model, both acting on falling edges
   always @(negedge clk) begin
      if (pend) begin pidx++; pend = 0; end
      pay_valid_i = (pidx < plen);
      if (pay_valid_i && pidx == stall_at && stall_cnt < stall_len) begin
         pay_valid_i = 1'b0;
         stall_cnt++;
      end
      pay_data_i = pbuf[pidx[5:0]];
      if (pay_valid_i && pay_ready_o) pend = 1;

      if (!rst_n || done_o || err_o) begin
         pst = 0; link_i = '0; pcnt = 0;
      end else if (pst == 0) begin
         if (link_o == 5'b01000 && !mute_start) begin
            if (pcnt >= peer_dly) begin link_i = 5'b00001; pst = 1; pcnt = 0; end
            else pcnt++;
         end
      end else begin
         if (link_o[4] && !link_i[4]) begin
            if (pcnt >= peer_dly && nrx != mute_at) begin
               lo_nib = link_o[3:0];
               if (nrx == 0) first_lo = link_o;
               link_i[4] = 1'b1; pcnt = 0;
            end else pcnt++;
         end else if (!link_o[4] && link_i[4]) begin
            if (pcnt >= peer_dly) begin
               if (nrx == 0) first_hi = link_o;
               rx[nrx[6:0]] = {link_o[3:0], lo_nib};
               nrx++;
               link_i[4] = 1'b0; pcnt = 0;
            end else pcnt++;
         end
      end
   end

   task automatic chk(input string req, input string what, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] addr_byte(input logic [7:0] salt, input int k);
      return 8'(salt + 8'h30 + k * 7);
   endfunction

   task automatic start_pkt(input int pl, input logic [7:0] base, input logic [7:0] step,
                            input logic [7:0] salt, input int dly, input int tmo);
      for (int i = 0; i < 64; i++) pbuf[i] = 8'(base + i * step);
      for (int k = 0; k < AB; k++) addr_cfg_i[8*k +: 8] = addr_byte(salt, k);
      plen = pl; pidx = 0; pend = 0; nrx = 0; stall_cnt = 0;
      peer_dly = dly; timeout_cfg_i = TW'(tmo);
      first_lo = '0; first_hi = '0;
      @(negedge clk);
      start_i = 1'b1; pay_len_i = PW'(pl);
      @(negedge clk);
      start_i = 1'b0;
      busy_cyc = busy_o ? 1 : 0;
   endtask

   task automatic wait_end();
      got_done = 0; got_err = 0;
      for (int c = 0; c < 8000; c++) begin
         @(negedge clk);
         if (done_o) got_done = 1;
         if (err_o) got_err = 1;
         if (done_o || err_o) break;
         if (busy_o) busy_cyc++;
      end
   endtask

   task automatic check_pkt(input int pl, input logic [7:0] salt, input logic [15:0] exp_len);
      logic [7:0] s;
      int bad;
      chk("R7", "done pulse", got_done, 1);
      chk("R7", "no error", got_err, 0);
      chk("R7", "lines idle at end", {busy_o, link_o}, 0);
      chk("R4", "byte count", nrx, pl + 17);
      chk("R3", "first low-nibble phase", first_lo, {1'b1, exp_len[3:0]});
      chk("R3", "first high-nibble phase", first_hi, {1'b0, exp_len[7:4]});
      chk("R4", "length low", rx[0], exp_len[7:0]);
      chk("R4", "length high", rx[1], exp_len[15:8]);
      bad = 0;
      s = 8'h08;
      for (int k = 0; k < AB; k++) begin
         if (rx[2+k] != addr_byte(salt, k)) bad++;
         s = s + addr_byte(salt, k);
      end
      chk("R5", "address mismatches", bad, 0);
      chk("R5", "type bytes", {rx[14], rx[15]}, 16'h0800);
      bad = 0;
      for (int i = 0; i < pl; i++) begin
         if (rx[16+i] != pbuf[i]) bad++;
         s = s + pbuf[i];
      end
      chk("R5", "payload mismatches", bad, 0);
      chk("R6", "checksum", rx[16+pl], s);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1", "reset state", {busy_o, pay_ready_o, done_o, err_o, link_o}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R1", "idle after reset", {busy_o, pay_ready_o, link_o}, 0);

      // table walk: normal packets
      for (int v = 0; v < 5; v++) begin
         start_pkt(int'(VECS[v].plen), VECS[v].base, VECS[v].step, VECS[v].salt,
                   int'(VECS[v].dly), 50);
         wait_end();
         check_pkt(int'(VECS[v].plen), VECS[v].salt, VECS[v].exp_len);
      end

      // R2: request held while peer stays silent
      mute_start = 1;
      start_pkt(3, 8'h5A, 8'h03, 8'h44, 0, 1000);
      repeat (12) @(negedge clk);
      chk("R2", "request pattern held", link_o, 5'b01000);
      chk("R2", "no byte before answer", nrx, 0);
      mute_start = 0;
      wait_end();
      check_pkt(3, 8'h44, 16'd17);

      // R10: start pulses while busy are ignored
      start_pkt(6, 8'h21, 8'h05, 8'h55, 1, 50);
      repeat (6) begin
         @(negedge clk);
         start_i = 1'b1; pay_len_i = PW'(30);
      end
      @(negedge clk);
      start_i = 1'b0;
      wait_end();
      check_pkt(6, 8'h55, 16'd20);
      begin
         int noisy = 0;
         repeat (12) begin
            @(negedge clk);
            if (busy_o || link_o != 0) noisy++;
         end
         chk("R10", "no second packet", noisy, 0);
      end

      // R8: start answer never comes
      mute_start = 1;
      start_pkt(2, 8'h01, 8'h01, 8'h00, 0, 5);
      wait_end();
      mute_start = 0;
      chk("R8", "error on start timeout", got_err, 1);
      chk("R8", "request phase length", busy_cyc, 6);
      chk("R8", "lines cleared", {busy_o, link_o}, 0);

      // R8: acknowledge missing mid-frame
      mute_at = 3;
      start_pkt(4, 8'h90, 8'h01, 8'h66, 0, 8);
      wait_end();
      mute_at = -1;
      chk("R8", "error on handshake timeout", {got_err, got_done}, 2'b10);
      chk("R8", "bytes before abort", nrx, 3);
      chk("R8", "lines cleared", {busy_o, link_o}, 0);

      // R6: fresh sum after an abort
      start_pkt(7, 8'hC3, 8'h11, 8'h77, 0, 50);
      wait_end();
      check_pkt(7, 8'h77, 16'd21);

      // R9: long payload stall with a short timeout
      stall_at = 2; stall_len = 25;
      start_pkt(6, 8'h3C, 8'h09, 8'h88, 0, 3);
      wait_end();
      stall_at = -1; stall_len = 0;
      chk("R9", "stall did not abort", got_err, 0);
      check_pkt(6, 8'h88, 16'd20);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end
endmodule